// File: doc/BRIEF.md
# CEC Message Buffer Register Interface

This block sits on the host side of a bridge between a consumer-electronics control line and a byte-oriented serial register bus. The host talks to it through byte strobes (transfer start, byte write, byte read, transfer stop). The first byte written after a start loads an address pointer, and the pointer steps up by one after every data byte. Through this pointer the host reaches a control register, a 16-bit acknowledge mask and a bank of message data registers. The first data register always carries the message length.

On the outbound path the block watches the data registers being written. It commits a message to the line-side transmitter with a one-cycle `tx_start` pulse as soon as the length is satisfied, or when the top data register is reached. A message that is short, or that is cut off before the stop, is never sent. On the inbound path the line side delivers a whole message with `rx_load`. The block raises `irq` and the status bit, serves the bytes to host reads with 00h/FFh padding, and drops the interrupt when the message has been fully read or abandoned.

A three-state host sequencer drives the register accesses. Its states are `ST_IDLE` (no transfer), `ST_ADDR` (start seen, waiting for the pointer byte or a direct read) and `ST_XFER` (data bytes). Its transitions are: IDLE→ADDR on start; ADDR→XFER on a pointer write or a direct read; XFER→ADDR on a repeated start; any state→IDLE on stop.

Top module: `cec_msgbuf_regs`

## Requirements
- R1: After reset `irq`, `dev_on`, `tx_start` and `ack_mask` are 0, and `bus_rdata` is 00h.
- R2: The first byte written after a start loads the pointer, and each later data byte advances it by one. Register 04h feeds `ack_mask[15:8]` and 05h feeds `ack_mask[7:0]`, where bit n enables logical address n, so the sequence 04h,00h,08h gives `ack_mask` = 0008h. Written registers read back their values.
- R3: Control register 03h bit 6 is the ON bit and drives `dev_on`. While it is 0, data register writes are not stored or sent and `rx_load` is ignored.
- R4: Data registers occupy 07h..16h and byte 07h holds the length L. When the register at index L-1 is written in order within one transfer, `tx_start` pulses in the following cycle with `tx_len` = L. Later data bytes of that transfer are neither stored nor sent.
- R5: A length below 3 is never sent.
- R6: A transfer that stops before L data registers are written sends nothing.
- R7: If register 16h is written in order while L exceeds 16, the message is committed with `tx_len` = 16.
- R8: An `rx_load` carrying a length of at least 3 (byte 0 of `rx_msg`) sets `irq` in the next cycle while `dev_on` is 1. Status register 06h reads back with bit 0 equal to `irq`.
- R9: While `irq` is 0, a read of 07h returns 00h and reads of other data registers return FFh.
- R10: A read issued straight after a start, with no pointer byte, after data registers were written in an earlier transfer, begins at 07h.
- R11: Reads beyond the message length return FFh. `irq` falls in the cycle after the last valid byte is read.
- R12: If a transfer that read message bytes stops before the last valid byte, `irq` clears and the message is gone: a new read of 07h returns 00h.
- R13: An `rx_load` while `irq` is set is ignored, unless it coincides with the read of the last valid byte. In that case the new message replaces the old one and `irq` stays 1. An `rx_load` with a length below 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Transfer start strobe |
| bus_stop | input | 1 | Transfer stop strobe |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Byte read strobe |
| bus_rdata | output | 8 | Read byte, valid the cycle after `bus_rd` |
| rx_load | input | 1 | Received message delivery strobe |
| rx_msg | input | 128 | Received message, byte i at bits 8i+7:8i |
| tx_start | output | 1 | One-cycle commit of an outbound message |
| tx_len | output | 5 | Committed message length |
| tx_msg | output | 128 | Outbound buffer, byte i at bits 8i+7:8i |
| irq | output | 1 | Received message waiting |
| dev_on | output | 1 | ON bit of the control register |
| ack_mask | output | 16 | Logical-address acknowledge mask |

## Verification
Delivering a received message and reading the last valid byte of the current one can fall in the same clock edge. The first would set the interrupt and the second would clear it. The bench provokes this by pulsing `rx_load` in the same cycle as the final read strobe. It judges the outcome by three checks: the returned byte is the old message's last byte, `irq` stays high, and the next transfer reads the new message from 07h.

// File: rtl/cec_msgbuf_pkg.sv
package cec_msgbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_XFER = 2'd2
    } hst_state_e;

    localparam logic [7:0] REG_CTRL  = 8'h03;
    localparam logic [7:0] REG_ACKH  = 8'h04;
    localparam logic [7:0] REG_ACKL  = 8'h05;
    localparam logic [7:0] REG_STAT  = 8'h06;
    localparam logic [7:0] REG_DATA0 = 8'h07;

    localparam int unsigned CTRL_ON_BIT = 6;
    localparam logic [7:0]  MIN_LEN     = 8'd3;
    localparam logic [7:0]  PAD_BYTE    = 8'hFF;

endpackage

// File: rtl/cec_host_fsm.sv
module cec_host_fsm
    import cec_msgbuf_pkg::*;
#(
    parameter int NUM_DATA = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic       acc_wr,
    output logic       acc_rd,
    output logic [7:0] acc_addr,
    output logic       tr_begin,
    output logic       tr_end
);

    localparam logic [7:0] DATA_END = REG_DATA0 + 8'(NUM_DATA);

    hst_state_e state_q, state_d;
    logic [7:0] ptr_q;
    logic       dirty_q;
    logic       ptr_load;
    logic       plain;

    // next-state logic and state register
    always_comb begin
        state_d = state_q;
        if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: if (bus_wr || bus_rd) state_d = ST_XFER;
                ST_XFER: state_d = ST_XFER;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        plain    = !bus_start && !bus_stop;
        tr_begin = bus_start && !bus_stop;
        tr_end   = (bus_stop || bus_start) && (state_q != ST_IDLE);
        ptr_load = 1'b0;
        acc_wr   = 1'b0;
        acc_rd   = 1'b0;
        acc_addr = ptr_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: begin
                ptr_load = plain && bus_wr;
                acc_rd   = plain && bus_rd && !bus_wr;
                if (dirty_q) acc_addr = REG_DATA0;
            end
            ST_XFER: begin
                acc_wr = plain && bus_wr;
                acc_rd = plain && bus_rd && !bus_wr;
            end
            default: ;
        endcase
    end

    // pointer and write-then-read redirect flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= 8'h00;
            dirty_q <= 1'b0;
        end else if (ptr_load) begin
            ptr_q   <= bus_wdata;
            dirty_q <= 1'b0;
        end else if (acc_rd) begin
            ptr_q   <= acc_addr + 8'd1;
            dirty_q <= 1'b0;
        end else if (acc_wr) begin
            ptr_q <= acc_addr + 8'd1;
            if (acc_addr >= REG_DATA0 && acc_addr < DATA_END) dirty_q <= 1'b1;
        end
    end

    AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && acc_rd)); // R2

endmodule

// File: rtl/cec_tx_buf.sv
module cec_tx_buf
    import cec_msgbuf_pkg::*;
#(
    parameter int NUM_DATA = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dev_on,
    input  logic                        tr_begin,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_DATA)-1:0] wr_idx,
    input  logic [7:0]                  wr_data,
    output logic                        tx_start,
    output logic [$clog2(NUM_DATA+1)-1:0] tx_len,
    output logic [NUM_DATA*8-1:0]       tx_msg
);

    localparam int IDX_W = $clog2(NUM_DATA);
    localparam int LEN_W = $clog2(NUM_DATA+1);

    logic [7:0]       mem_q [NUM_DATA];
    logic [LEN_W-1:0] next_q;
    logic             done_q;
    logic             store;
    logic             hit;
    logic             commit;
    logic [7:0]       idx8;

    always_comb begin
        idx8   = 8'(wr_idx);
        store  = wr_en && dev_on && !done_q;
        hit    = store && (LEN_W'(wr_idx) == next_q);
        commit = hit && (idx8 >= 8'd2) && (mem_q[0] >= MIN_LEN) &&
                 ((idx8 + 8'd1 == mem_q[0]) || (idx8 == 8'(NUM_DATA - 1)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DATA; i++) mem_q[i] <= 8'h00;
            next_q   <= '0;
            done_q   <= 1'b0;
            tx_start <= 1'b0;
            tx_len   <= '0;
        end else begin
            tx_start <= commit;
            if (tr_begin) begin
                next_q <= '0;
                done_q <= 1'b0;
            end else if (store) begin
                mem_q[wr_idx] <= wr_data;
                if (hit)    next_q <= next_q + LEN_W'(1);
                if (commit) begin
                    done_q <= 1'b1;
                    tx_len <= (mem_q[0] > 8'(NUM_DATA)) ? LEN_W'(NUM_DATA)
                                                       : mem_q[0][LEN_W-1:0];
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_flat
        assign tx_msg[8*g +: 8] = mem_q[g];
    end

    AST_TX_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (tx_len >= LEN_W'(3) && tx_len <= LEN_W'(NUM_DATA))); // R5
    AST_TX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R4
    AST_TX_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(dev_on)); // R3

endmodule

// File: rtl/cec_rx_buf.sv
module cec_rx_buf
    import cec_msgbuf_pkg::*;
#(
    parameter int NUM_DATA = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dev_on,
    input  logic                        rx_load,
    input  logic [NUM_DATA*8-1:0]       rx_msg,
    input  logic                        rd_en,
    input  logic [$clog2(NUM_DATA)-1:0] rd_idx,
    input  logic                        tr_end,
    output logic                        irq,
    output logic [7:0]                  rd_byte
);

    localparam int LEN_W = $clog2(NUM_DATA+1);

    logic [7:0]       mem_q [NUM_DATA];
    logic [LEN_W-1:0] len_q;
    logic             touched_q;
    logic [7:0]       in_len;
    logic             rx_ok;
    logic             valid_rd;
    logic             rd_clr;
    logic             accept;
    logic             discard;

    always_comb begin
        in_len   = rx_msg[7:0];
        rx_ok    = rx_load && dev_on && (in_len >= MIN_LEN);
        valid_rd = rd_en && irq;
        rd_clr   = valid_rd && (LEN_W'(rd_idx) == len_q - LEN_W'(1));
        accept   = rx_ok && (!irq || rd_clr);
        discard  = tr_end && irq && touched_q;
        if (!irq)                         rd_byte = (rd_idx == '0) ? 8'h00 : PAD_BYTE;
        else if (LEN_W'(rd_idx) < len_q)  rd_byte = mem_q[rd_idx];
        else                              rd_byte = PAD_BYTE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DATA; i++) mem_q[i] <= 8'h00;
            len_q     <= '0;
            irq       <= 1'b0;
            touched_q <= 1'b0;
        end else if (accept) begin
            for (int i = 0; i < NUM_DATA; i++) mem_q[i] <= rx_msg[8*i +: 8];
            len_q     <= (in_len > 8'(NUM_DATA)) ? LEN_W'(NUM_DATA) : in_len[LEN_W-1:0];
            irq       <= 1'b1;
            touched_q <= 1'b0;
        end else if (rd_clr || discard) begin
            irq       <= 1'b0;
            touched_q <= 1'b0;
        end else if (valid_rd) begin
            touched_q <= 1'b1;
        end
    end

    AST_IRQ_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dev_on)); // R8
    AST_IRQ_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !rx_ok) |=> !irq); // R11
    AST_PARTIAL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_end && irq && touched_q && !rx_ok) |=> !irq); // R12

endmodule

// File: rtl/cec_msgbuf_regs.sv
module cec_msgbuf_regs
    import cec_msgbuf_pkg::*;
#(
    parameter int NUM_DATA = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_start,
    input  logic                          bus_stop,
    input  logic                          bus_wr,
    input  logic [7:0]                    bus_wdata,
    input  logic                          bus_rd,
    output logic [7:0]                    bus_rdata,
    input  logic                          rx_load,
    input  logic [NUM_DATA*8-1:0]         rx_msg,
    output logic                          tx_start,
    output logic [$clog2(NUM_DATA+1)-1:0] tx_len,
    output logic [NUM_DATA*8-1:0]         tx_msg,
    output logic                          irq,
    output logic                          dev_on,
    output logic [15:0]                   ack_mask
);

    localparam int         IDX_W    = $clog2(NUM_DATA);
    localparam logic [7:0] DATA_END = REG_DATA0 + 8'(NUM_DATA);

    logic             acc_wr;
    logic             acc_rd;
    logic [7:0]       acc_addr;
    logic             tr_begin;
    logic             tr_end;
    logic             in_data;
    logic [7:0]       off;
    logic [IDX_W-1:0] data_idx;
    logic [7:0]       rx_byte;
    logic [7:0]       ctrl_q;
    logic [7:0]       ackh_q;
    logic [7:0]       ackl_q;

    cec_host_fsm #(.NUM_DATA(NUM_DATA)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .acc_addr  (acc_addr),
        .tr_begin  (tr_begin),
        .tr_end    (tr_end)
    );

    always_comb begin
        in_data  = (acc_addr >= REG_DATA0) && (acc_addr < DATA_END);
        off      = acc_addr - REG_DATA0;
        data_idx = off[IDX_W-1:0];
    end

    cec_tx_buf #(.NUM_DATA(NUM_DATA)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_on   (dev_on),
        .tr_begin (tr_begin),
        .wr_en    (acc_wr && in_data),
        .wr_idx   (data_idx),
        .wr_data  (bus_wdata),
        .tx_start (tx_start),
        .tx_len   (tx_len),
        .tx_msg   (tx_msg)
    );

    cec_rx_buf #(.NUM_DATA(NUM_DATA)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_on  (dev_on),
        .rx_load (rx_load),
        .rx_msg  (rx_msg),
        .rd_en   (acc_rd && in_data),
        .rd_idx  (data_idx),
        .tr_end  (tr_end),
        .irq     (irq),
        .rd_byte (rx_byte)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
            ackh_q <= 8'h00;
            ackl_q <= 8'h00;
        end else if (acc_wr) begin
            unique case (acc_addr)
                REG_CTRL: ctrl_q <= bus_wdata;
                REG_ACKH: ackh_q <= bus_wdata;
                REG_ACKL: ackl_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign dev_on   = ctrl_q[CTRL_ON_BIT];
    assign ack_mask = {ackh_q, ackl_q};

    // registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
        end else if (acc_rd) begin
            if (in_data) begin
                bus_rdata <= rx_byte;
            end else begin
                unique case (acc_addr)
                    REG_CTRL: bus_rdata <= ctrl_q;
                    REG_ACKH: bus_rdata <= ackh_q;
                    REG_ACKL: bus_rdata <= ackl_q;
                    REG_STAT: bus_rdata <= {7'd0, irq};
                    default:  bus_rdata <= PAD_BYTE;
                endcase
            end
        end
    end

    AST_STATUS_MIRRORS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr == REG_STAT) |=> (bus_rdata == {7'd0, $past(irq)})); // R8
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && (acc_addr == REG_ACKH || acc_addr == REG_ACKL)) |=> $stable(ack_mask)); // R2

endmodule

// File: tb/cec_msgbuf_regs_tb_top.sv
module cec_msgbuf_regs_tb_top;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_start = 1'b0, bus_stop = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_wdata = 8'h00;
    logic [7:0]   bus_rdata;
    logic         rx_load = 1'b0;
    logic [127:0] rx_msg = '0;
    logic         tx_start;
    logic [4:0]   tx_len;
    logic [127:0] tx_msg;
    logic         irq, dev_on;
    logic [15:0]  ack_mask;

    int n_chk = 0;
    int n_err = 0;
    int tx_cnt = 0;
    int cyc = 0;

    cec_msgbuf_regs #(.NUM_DATA(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_load(rx_load), .rx_msg(rx_msg), .tx_start(tx_start), .tx_len(tx_len),
        .tx_msg(tx_msg), .irq(irq), .dev_on(dev_on), .ack_mask(ack_mask)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_start) tx_cnt <= tx_cnt + 1;
        if (cyc > 50000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected=<50000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // rows: {register, value written, value read back}
    localparam logic [23:0] REG_VEC [4] = '{
        {8'h04, 8'h00, 8'h00},
        {8'h05, 8'h08, 8'h08},
        {8'h03, 8'h40, 8'h40},
        {8'h06, 8'h55, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bstart();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask
    task automatic bstop();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask
    task automatic bwr(input logic [7:0] b);
        bus_wr = 1'b1; bus_wdata = b; @(negedge clk); bus_wr = 1'b0;
    endtask
    task automatic brd(output logic [7:0] b);
        bus_rd = 1'b1; @(negedge clk); bus_rd = 1'b0; b = bus_rdata;
    endtask
    task automatic rxl(input logic [127:0] m);
        rx_load = 1'b1; rx_msg = m; @(negedge clk); rx_load = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        int t0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(irq == 0 && dev_on == 0 && tx_start == 0, "R1", {irq, dev_on, tx_start}, 0);
        chk(ack_mask == 16'h0 && bus_rdata == 8'h00, "R1", ack_mask, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 device off: writes and loads ignored
        bstart(); bwr(8'h07); bwr(8'h03); bwr(8'hA1); bwr(8'hA2); bstop();
        chk(tx_cnt == 0 && tx_msg == '0, "R3", tx_cnt, 0);
        rxl(128'h0000_0000_0000_0000_0000_0000_00C2_C103);
        chk(irq == 0, "R3", irq, 0);

        // R2 R3 register table
        for (int i = 0; i < 4; i++) begin
            bstart(); bwr(REG_VEC[i][23:16]); bwr(REG_VEC[i][15:8]); bstop();
            bstart(); bwr(REG_VEC[i][23:16]); brd(r); bstop();
            chk(r == REG_VEC[i][7:0], "R2", r, REG_VEC[i][7:0]);
        end
        chk(ack_mask == 16'h0008, "R2", ack_mask, 16'h0008);
        chk(dev_on == 1, "R3", dev_on, 1);
        bstart(); bwr(8'h04); bwr(8'h12); bwr(8'h34); bstop();
        chk(ack_mask == 16'h1234, "R2", ack_mask, 16'h1234);

        // R4 commit at length, extra byte ignored
        t0 = tx_cnt;
        bstart(); bwr(8'h07); bwr(8'h04); bwr(8'h11); bwr(8'h22); bwr(8'h33);
        chk(tx_start == 1 && tx_len == 5'd4, "R4", {tx_start, tx_len}, {1'b1, 5'd4});
        bwr(8'h99); bstop();
        chk(tx_msg[39:0] == 40'h00_3322_1104, "R4", tx_msg[39:0], 40'h0033221104);
        chk(tx_cnt == t0 + 1, "R4", tx_cnt, t0 + 1);

        // R5 short length never sent
        t0 = tx_cnt;
        bstart(); bwr(8'h07); bwr(8'h02); bwr(8'hAA); bwr(8'hBB); bwr(8'hCC); bstop();
        chk(tx_cnt == t0, "R5", tx_cnt, t0);

        // R6 partial write dropped
        bstart(); bwr(8'h07); bwr(8'h05); bwr(8'h01); bwr(8'h02); bstop();
        bstart(); bwr(8'h0A); bwr(8'h03); bstop();
        chk(tx_cnt == t0, "R6", tx_cnt, t0);

        // R7 highest register reached with a long length
        t0 = tx_cnt;
        bstart(); bwr(8'h07); bwr(8'h20);
        for (int i = 1; i < N; i++) bwr(8'(8'h40 + i));
        chk(tx_start == 1 && tx_len == 5'd16, "R7", tx_len, 16);
        bwr(8'h77); bstop();
        chk(tx_cnt == t0 + 1 && tx_msg[127:120] == 8'h4F, "R7", tx_msg[127:120], 8'h4F);

        // R9 reads with no message
        bstart(); bwr(8'h07); brd(r);
        chk(r == 8'h00, "R9", r, 0);
        brd(r);
        chk(r == 8'hFF, "R9", r, 8'hFF);
        bstop();

        // R8 load and status
        rxl(128'h3020_1004);
        chk(irq == 1, "R8", irq, 1);
        bstart(); bwr(8'h06); brd(r); bstop();
        chk(r == 8'h01, "R8", r, 1);

        // R11 full read, padding, interrupt timing
        bstart(); bwr(8'h07); brd(r); brd(r); brd(r);
        chk(r == 8'h20 && irq == 1, "R11", {r, irq}, {8'h20, 1'b1});
        brd(r);
        chk(r == 8'h30 && irq == 0, "R11", {r, irq}, {8'h30, 1'b0});
        bstop();
        bstart(); bwr(8'h06); brd(r); bstop();
        chk(r == 8'h00, "R8", r, 0);
        rxl(128'h20_1003);
        bstart(); bwr(8'h09); brd(r); brd(r);
        chk(r == 8'hFF, "R11", r, 8'hFF);
        bstop();
        bstart(); bwr(8'h07); brd(r); brd(r); brd(r); bstop();
        chk(irq == 0, "R11", irq, 0);

        // R12 partial read discards
        rxl(128'h04_0302_0105);
        bstart(); bwr(8'h07); brd(r); brd(r); bstop();
        chk(irq == 0, "R12", irq, 0);
        bstart(); bwr(8'h07); brd(r); bstop();
        chk(r == 8'h00, "R12", r, 0);

        // R10 read after write starts at first data register
        rxl(128'h11_4003);
        t0 = tx_cnt;
        bstart(); bwr(8'h07); bwr(8'h09); bwr(8'hAA); bstop();
        bstart(); brd(r);
        chk(r == 8'h03, "R10", r, 3);
        brd(r); brd(r);
        chk(r == 8'h11 && irq == 0, "R10", r, 8'h11);
        bstop();
        chk(tx_cnt == t0, "R6", tx_cnt, t0);

        // R13 load together with last-byte read
        rxl(128'hA2_A103);
        bstart(); bwr(8'h07); brd(r); brd(r);
        bus_rd = 1'b1; rx_load = 1'b1; rx_msg = 128'hB2_B103;
        @(negedge clk);
        bus_rd = 1'b0; rx_load = 1'b0; r = bus_rdata;
        chk(r == 8'hA2 && irq == 1, "R13", {r, irq}, {8'hA2, 1'b1});
        bstop();
        bstart(); bwr(8'h07); brd(r); brd(r);
        chk(r == 8'hB1, "R13", r, 8'hB1);
        brd(r); bstop();
        chk(irq == 0, "R13", irq, 0);
        // load while pending is ignored
        rxl(128'hC2_C103);
        rxl(128'hD2_D103);
        bstart(); bwr(8'h08); brd(r); bstop();
        chk(r == 8'hC1, "R13", r, 8'hC1);
        bstart(); bwr(8'h07); brd(r); brd(r); brd(r); bstop();
        // short received length ignored
        rxl(128'hE1_02);
        chk(irq == 0, "R13", irq, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule